// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small accumulator machine. One 16-entry, 8-bit memory holds both the program and its operands. Each instruction byte names an operation in its high nibble and a memory location in its low nibble. The supported operations are load, add, subtract, write to the output port, and stop. The core is meant to run short fixed programs, such as sequencing or bring-up tasks inside a larger chip.

The program image is written through a preload port while reset is held. When reset is released, the core starts at location 0 and runs until it reaches a stop instruction. Each output instruction shows up as a one-clock strobe alongside the accumulator value. A stop instruction raises a flag that stays high until the next reset.

Top module: `acc_core`

## Requirements
- R1: While reset is active and right after it, `out_data` is 0x00, `out_valid` is 0 and `halted` is 0. The accumulator is cleared and the program counter starts at location 0.
- R2: Bits [7:4] of an instruction byte are the opcode and bits [3:0] are the memory location it uses.
- R3: Opcode 0x0 copies the byte at the named location into the accumulator.
- R4: Opcode 0x1 adds the byte at the named location to the accumulator, modulo 256.
- R5: Opcode 0x2 subtracts the byte at the named location from the accumulator, modulo 256.
- R6: Opcode 0xE places the accumulator on `out_data` and raises `out_valid` for exactly one clock. `out_data` keeps its value until the next 0xE instruction.
- R7: Opcode 0xF raises `halted`, which then stays high until reset. No further output strobe occurs and `out_data` does not change.
- R8: Opcodes 0x3 through 0xD have no effect on the accumulator or the output and take 4 cycles.
- R9: The program counter wraps from location 15 to location 0.
- R10: Opcodes 0x0, 0x1 and 0x2 take 5 cycles; all other opcodes take 4. The first instruction begins on the third rising edge after `rst_n` goes high. The output strobe is visible after the final edge of the 0xE instruction, and `halted` is visible after the final edge of the 0xF instruction.
- R11: A preload write (`pre_we` high) changes memory only while reset is active. This window covers `rst_n` low and the two edges that follow its release. At any other time the write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| pre_we | input | 1 | Preload write enable, honoured only during reset |
| pre_addr | input | 4 | Preload memory location |
| pre_data | input | 8 | Preload byte |
| out_data | output | 8 | Output port value |
| out_valid | output | 1 | One-clock strobe for each output instruction |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
A wrong sequencer state or program counter changes when output strobes occur. This is visible at the ports by the next output instruction, because the cycle count of every instruction is fixed. A corrupted accumulator or ALU result shows up as a wrong `out_data` value at the next strobe. The scoreboard compares both the value and the exact cycle of each strobe. A preload write that leaks outside reset is caught when a later program reads the protected location back out through the output port.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    ST_ADDR  = 3'd0,
    ST_FETCH = 3'd1,
    ST_INC   = 3'd2,
    ST_EX1   = 3'd3,
    ST_EX2   = 3'd4,
    ST_HALT  = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2
  } alu_op_e;

  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_LOAD = 4'h0;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_OUT  = 4'hE;
  localparam logic [OPC_W-1:0] OPC_STOP = 4'hF;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // write port, gated by its enable
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // registered read port, one cycle latency
  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    unique case (op)
      ALU_ADD: result = acc + operand;
      ALU_SUB: result = acc - operand;
      default: result = operand;
    endcase
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] alu_result,
  output alu_op_e           alu_op,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] od_q;
  logic              ov_q, ov_d;
  logic              ir_en, pc_en, acc_en, od_en;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] operand_addr;

  assign opcode       = ir_q[DATA_W-1 -: OPC_W];
  assign operand_addr = ir_q[ADDR_W-1:0];

  // next-state and enable logic
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q + 1'b1;
    ov_d    = 1'b0;
    ir_en   = 1'b0;
    pc_en   = 1'b0;
    acc_en  = 1'b0;
    od_en   = 1'b0;
    unique case (state_q)
      ST_ADDR:  state_d = ST_FETCH;
      ST_FETCH: begin
        ir_en   = 1'b1;
        state_d = ST_INC;
      end
      ST_INC: begin
        pc_en   = 1'b1;
        state_d = ST_EX1;
      end
      ST_EX1: begin
        unique case (opcode)
          OPC_LOAD, OPC_ADD, OPC_SUB: state_d = ST_EX2;
          OPC_OUT: begin
            od_en   = 1'b1;
            ov_d    = 1'b1;
            state_d = ST_ADDR;
          end
          OPC_STOP: state_d = ST_HALT;
          default:  state_d = ST_ADDR;
        endcase
      end
      ST_EX2: begin
        acc_en  = 1'b1;
        state_d = ST_ADDR;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_ADDR;
    endcase
  end

  always_comb begin
    unique case (opcode)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_SUB: alu_op = ALU_SUB;
      default: alu_op = ALU_PASS;
    endcase
  end

  // operand read issued in EX1, instruction read in ADDR
  assign raddr = (state_q == ST_EX1) ? operand_addr : pc_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ADDR;
      pc_q    <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      od_q    <= '0;
      ov_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ov_q    <= ov_d;
      if (pc_en)  pc_q  <= pc_d;
      if (ir_en)  ir_q  <= rdata;
      if (acc_en) acc_q <= alu_result;
      if (od_en)  od_q  <= acc_q;
    end
  end

  assign acc       = acc_q;
  assign pc        = pc_q;
  assign out_data  = od_q;
  assign out_valid = ov_q;
  assign halted    = (state_q == ST_HALT);
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   core_rst_n;
  logic [DATA_W-1:0]      mem_rdata;
  logic [ADDR_W-1:0]      mem_raddr;
  logic [DATA_W-1:0]      acc;
  logic [DATA_W-1:0]      alu_result;
  logic [ADDR_W-1:0]      pc;
  alu_op_e                alu_op;

  // reset: asserted at once, released after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_STAGES-1];

  acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (pre_we & ~core_rst_n),
    .waddr (pre_addr),
    .wdata (pre_data),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (alu_op),
    .acc     (acc),
    .operand (mem_rdata),
    .result  (alu_result)
  );

  acc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .rdata      (mem_rdata),
    .alu_result (alu_result),
    .alu_op     (alu_op),
    .acc        (acc),
    .raddr      (mem_raddr),
    .pc         (pc),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .halted     (halted)
  );
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              halted,
  input logic [DATA_W-1:0] out_data,
  input logic [ADDR_W-1:0] pc
);
  // R6: strobe lasts one clock
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6: output value only moves together with a strobe
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R7: halt is sticky
  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R7: no strobe once halted
  assert_quiet_when_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !out_valid);

  // R9: program counter only steps by one, wrapping at the top
  assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == ADDR_W'($past(pc) + 1'b1)));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .halted    (halted),
  .out_data  (out_data),
  .pc        (pc)
);

// File: tb/tb_acc_core.sv
module tb_acc_core;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic          halted;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0] img [16];

  typedef struct {
    logic [DW-1:0] data;
    int            at;
    string         req;
  } exp_t;
  exp_t exp_q[$];

  acc_core #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .out_data(out_data), .out_valid(out_valid),
    .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor: pop expected strobes and compare value and cycle
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected strobe", int'(out_data), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_data == e.data, {e.req, " data"}, int'(out_data), int'(e.data));
        check(cyc == e.at, {e.req, " R10 strobe cycle"}, cyc, e.at);
      end
    end
  end

  task automatic push_exp(input logic [DW-1:0] d, input int at, input string req);
    exp_t e;
    e.data = d; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic clear_img(input logic [DW-1:0] fill);
    for (int i = 0; i < 16; i++) img[i] = fill;
  endtask

  // hold reset, check idle outputs, preload all 16 words, release
  task automatic boot(input bit load_all);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(halted == 1'b0, "R1 halted in reset", halted, 0);
    check(out_data == '0, "R1 out_data in reset", int'(out_data), 0);
    if (load_all) begin
      for (int i = 0; i < 16; i++) begin
        pre_we = 1'b1; pre_addr = AW'(i); pre_data = img[i];
        @(negedge clk);
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        pre_we = 1'b1; pre_addr = AW'(i); pre_data = img[i];
        @(negedge clk);
      end
    end
    pre_we = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    // P1: load, add, add, subtract, output, stop
    clear_img(8'h00);
    img[0] = 8'h09; img[1] = 8'h1A; img[2] = 8'h1B; img[3] = 8'h2C;
    img[4] = 8'hE0; img[5] = 8'hF0;
    img[9] = 8'h01; img[10] = 8'h02; img[11] = 8'h03; img[12] = 8'h04;
    push_exp(8'h02, 26, "R3 R4 R5 R2 sum");
    boot(1'b1);
    @(negedge clk);
    check(out_data == '0 && !halted, "R1 idle after release", int'(out_data), 0);
    wait_to(29);
    check(halted == 1'b0, "R10 halted not yet", halted, 0);
    wait_to(30);
    check(halted == 1'b1, "R7 R10 halted raised", halted, 1);
    check(exp_q.size() == 0, "R6 all strobes seen", exp_q.size(), 0);

    // P2: wrap on subtract and add, undefined opcode, multiple outputs
    clear_img(8'h00);
    img[0] = 8'h09; img[1] = 8'h2A; img[2] = 8'hE0; img[3] = 8'h5C;
    img[4] = 8'h1B; img[5] = 8'hE0; img[6] = 8'h1C; img[7] = 8'hE0;
    img[8] = 8'hF0;
    img[9] = 8'h05; img[10] = 8'h07; img[11] = 8'hFF; img[12] = 8'h10;
    push_exp(8'hFE, 16, "R5 underflow");
    push_exp(8'hFD, 29, "R4 R8 wrap after nop");
    push_exp(8'h0D, 38, "R4 overflow");
    boot(1'b1);
    wait_to(42);
    check(halted == 1'b1, "R7 R8 halted", halted, 1);
    wait_to(62);
    check(halted == 1'b1, "R7 halt held", halted, 1);
    check(out_data == 8'h0D, "R7 out_data frozen", int'(out_data), 8'h0D);
    check(exp_q.size() == 0, "R6 all strobes seen", exp_q.size(), 0);
    // R11: write outside reset must be ignored
    pre_we = 1'b1; pre_addr = 4'd9; pre_data = 8'h99;
    @(negedge clk);
    pre_we = 1'b0;

    // P4: read location 9 back; expect the value from before the stray write
    img[0] = 8'h09; img[1] = 8'hE0; img[2] = 8'hF0;
    push_exp(8'h05, 11, "R11 preload ignored");
    boot(1'b0);
    wait_to(15);
    check(halted == 1'b1, "R7 R11 halted", halted, 1);
    check(exp_q.size() == 0, "R11 strobe seen", exp_q.size(), 0);

    // P3: program without stop, counter wraps 15 -> 0
    clear_img(8'h40);
    img[0] = 8'h0F; img[1] = 8'h1F; img[15] = 8'hE0;
    push_exp(8'hC0, 68, "R9 first pass");
    push_exp(8'hC0, 134, "R9 after wrap");
    boot(1'b1);
    wait_to(140);
    check(halted == 1'b0, "R9 still running", halted, 0);
    check(exp_q.size() == 0, "R9 strobes seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule